// File: doc/BRIEF.md
# Timed-Access Write Guard

This block protects a group of sensitive register bits against stray writes from a runaway program. Ordinary register writes go straight through. A write to a protected bit is honoured only while a short window is open, and the window opens only after software writes two fixed key bytes, in a fixed order, to one key register address.

The guard watches the register bus write strobe, address and data, along with a cycle tick that marks each instruction cycle. It produces a permit signal that the protected registers use as their write enable qualifier, and a status flag that shows whether the window is open. All time limits are counted in ticks. The key address, the two key bytes, the window length and the longest allowed gap between the key bytes are all parameters.

Top module: `timed_access_guard`

## Requirements
- R1: After reset, `win_open` is 0, and `prot_wr_ok` is 0 for any bus write.
- R2: A write of 0xAA to the key address (default 0xC7), followed by a write of 0x55 to that address, sets `win_open` to 1 from the clock edge that accepts the 0x55 write.
- R3: A 0x55 key write that does not follow an accepted 0xAA key write leaves `win_open` at 0.
- R4: The window remains open through exactly 3 ticks (WIN_CYC). A write that arrives in the same cycle as the third tick is still permitted, and `win_open` is 0 after that edge.
- R5: `prot_wr_ok` is 1 exactly when `bus_wr` is 1, the window is open and the address is not the key address. A protected write made while the window is closed is dropped, so the protected register keeps its old value.
- R6: A key write with any value other than 0xAA returns the sequence to idle and closes an open window. The only exception is a 0x55 write that completes an armed sequence.
- R7: The 0x55 write is accepted up to and including the cycle that carries the third tick (GAP_CYC) after the 0xAA write. After that tick the sequence is dropped and a late 0x55 opens nothing.
- R8: A 0xAA key write restarts the sequence at the armed step from any state, including while the window is open, and the window closes when this happens.
- R9: Protected writes do not close the window. Several of them may be made within one window.
- R10: When a key write and a tick fall in the same cycle, the key write decides the next state and the tick is ignored.

Key writes of 0xAA and 0x55 are only examples of the general rule. The rule is: a 0xAA key write always arms; a 0x55 key write opens only from the armed state; every other key write returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-cycle pulse per instruction cycle |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 8 | Register bus write address |
| bus_wdata | input | 8 | Register bus write data |
| prot_wr_ok | output | 1 | Write permit for protected registers |
| win_open | output | 1 | Window-open status |

## Verification
There are two collisions of interest. The first is a key write landing in the same cycle as the tick that would end the armed gap. The bench places the 0x55 write on the third tick after 0xAA and expects the window to open; it then repeats the sequence with the 0x55 written one cycle after that tick and expects the window to stay shut. The second is a protected write landing on the tick that closes the window. The bench drives both in one cycle and expects the write to be permitted and the window to be closed afterwards.

// File: rtl/ta_pkg.sv
package ta_pkg;

  typedef enum logic [1:0] {
    TA_IDLE  = 2'd0,
    TA_ARMED = 2'd1,
    TA_OPEN  = 2'd2
  } ta_state_e;

  typedef struct packed {
    logic hit;     // write to key address
    logic first;   // first key byte
    logic second;  // second key byte
  } ta_key_t;

endpackage

// File: rtl/ta_rst_sync.sv
module ta_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ta_key_decode.sv
module ta_key_decode
  import ta_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DW-1:0] KEY1     = 8'hAA,
  parameter logic [DW-1:0] KEY2     = 8'h55
) (
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          addr_is_key,
  output ta_key_t       key
);
  always_comb begin
    addr_is_key = (addr == KEY_ADDR);
    key.hit     = wr && addr_is_key;
    key.first   = key.hit && (wdata == KEY1);
    key.second  = key.hit && (wdata == KEY2);
  end
endmodule

// File: rtl/ta_tick_counter.sv
module ta_tick_counter #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || dec;
    cnt_d  = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (dec && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == {{(CW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/ta_seq_ctrl.sv
module ta_seq_ctrl
  import ta_pkg::*;
#(
  parameter int WIN_CYC = 3,
  parameter int GAP_CYC = 3,
  parameter int CW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  ta_key_t       key,
  input  logic          cnt_last,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          cnt_dec,
  output logic          open
);
  localparam logic [CW-1:0] GAP_LD = CW'(GAP_CYC);
  localparam logic [CW-1:0] WIN_LD = CW'(WIN_CYC);

  ta_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = GAP_LD;
    if (key.first) begin
      state_d  = TA_ARMED;
      cnt_load = 1'b1;
      cnt_val  = GAP_LD;
    end else if (key.second && state_q == TA_ARMED) begin
      state_d  = TA_OPEN;
      cnt_load = 1'b1;
      cnt_val  = WIN_LD;
    end else if (key.hit) begin
      state_d  = TA_IDLE;
    end else if (tick && state_q != TA_IDLE && cnt_last) begin
      state_d  = TA_IDLE;
    end
    cnt_dec = tick && !key.hit && (state_q != TA_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TA_IDLE;
    else        state_q <= state_d;
  end

  assign open = (state_q == TA_OPEN);
endmodule

// File: rtl/timed_access_guard.sv
module timed_access_guard
  import ta_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DW-1:0] KEY1     = 8'hAA,
  parameter logic [DW-1:0] KEY2     = 8'h55,
  parameter int            WIN_CYC  = 3,
  parameter int            GAP_CYC  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          prot_wr_ok,
  output logic          win_open
);
  localparam int MAXC = (WIN_CYC > GAP_CYC) ? WIN_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          rst_n_s;
  logic          addr_is_key;
  ta_key_t       key;
  logic          cnt_load, cnt_dec, cnt_last;
  logic [CW-1:0] cnt_val;

  ta_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ta_key_decode #(
    .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .KEY1(KEY1), .KEY2(KEY2)
  ) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .addr_is_key(addr_is_key), .key(key)
  );

  ta_seq_ctrl #(.WIN_CYC(WIN_CYC), .GAP_CYC(GAP_CYC), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .tick(cyc_tick), .key(key),
    .cnt_last(cnt_last), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .cnt_dec(cnt_dec), .open(win_open)
  );

  ta_tick_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .last(cnt_last)
  );

  assign prot_wr_ok = bus_wr && win_open && !addr_is_key;
endmodule

// File: rtl/ta_guard_checker.sv
module ta_guard_checker #(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DW-1:0] KEY1     = 8'hAA,
  parameter logic [DW-1:0] KEY2     = 8'h55,
  parameter int            WIN_CYC  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_tick,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          prot_wr_ok,
  input logic          win_open
);
  localparam int TW = $clog2(WIN_CYC + 1) + 1;
  logic [TW-1:0] open_ticks;
  logic          key_wr;

  assign key_wr = bus_wr && (bus_addr == KEY_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  open_ticks <= '0;
    else if (!win_open)          open_ticks <= '0;
    else if (cyc_tick && !key_wr) open_ticks <= open_ticks + 1'b1;
  end

  AST_PERMIT_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr_ok |-> (win_open && bus_wr)); // R5
  AST_NO_KEY_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |-> !prot_wr_ok); // R5
  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(key_wr && bus_wdata == KEY2)); // R2
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (open_ticks < TW'(WIN_CYC))); // R4
  AST_STRAY_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && bus_wdata != KEY2) |=> !win_open); // R6
  AST_PROT_WR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr_ok && !cyc_tick) |=> win_open); // R9
endmodule

bind timed_access_guard ta_guard_checker #(
  .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .KEY1(KEY1), .KEY2(KEY2),
  .WIN_CYC(WIN_CYC)
) u_ta_chk (
  .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .prot_wr_ok(prot_wr_ok),
  .win_open(win_open)
);

// File: tb/test_timed_access_guard.sv
`timescale 1ns/1ps
module test_timed_access_guard;
  localparam logic [7:0] KA   = 8'hC7;
  localparam logic [7:0] PROT = 8'h8E;

  logic clk, rst_n, cyc_tick, bus_wr;
  logic [7:0] bus_addr, bus_wdata;
  logic prot_wr_ok, win_open;
  logic [7:0] prot_reg;
  logic perm_s;
  int n_chk, n_fail;

  timed_access_guard i_timed_access_guard (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .prot_wr_ok(prot_wr_ok), .win_open(win_open)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // sample protected register, written only through the permit
  always_ff @(posedge clk) begin
    if (prot_wr_ok && bus_addr == PROT) prot_reg <= bus_wdata;
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, capture permit, return after the edge
  task automatic cyc(input logic wr, input logic [7:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; cyc_tick = tk;
    #1 perm_s = prot_wr_ok;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; cyc_tick = 1'b0;
  endtask

  task automatic idle(input logic tk);
    cyc(1'b0, 8'h00, 8'h00, tk);
  endtask

  task automatic open_seq();
    cyc(1'b1, KA, 8'hAA, 1'b0);
    cyc(1'b1, KA, 8'h55, 1'b0);
  endtask

  task automatic t_reset();
    check({7'd0, win_open}, 8'd0, "R1 win_open after reset");
    cyc(1'b1, PROT, 8'h11, 1'b0);
    check({7'd0, perm_s}, 8'd0, "R1 permit after reset");
    check(prot_reg, 8'h00, "R1 reg untouched");
  endtask

  task automatic t_open_and_len();
    cyc(1'b1, KA, 8'hAA, 1'b0);
    check({7'd0, win_open}, 8'd0, "R2 closed after first key");
    cyc(1'b1, KA, 8'h55, 1'b0);
    check({7'd0, win_open}, 8'd1, "R2 open after second key");
    idle(1'b1);
    idle(1'b1);
    check({7'd0, win_open}, 8'd1, "R4 open after two ticks");
    cyc(1'b1, PROT, 8'h5A, 1'b1);
    check({7'd0, perm_s}, 8'd1, "R4 write on closing tick permitted");
    check(prot_reg, 8'h5A, "R4 reg written");
    check({7'd0, win_open}, 8'd0, "R4 closed after third tick");
    cyc(1'b1, PROT, 8'hC3, 1'b0);
    check({7'd0, perm_s}, 8'd0, "R5 permit low when closed");
    check(prot_reg, 8'h5A, "R5 dropped write keeps value");
  endtask

  task automatic t_multi_write();
    open_seq();
    cyc(1'b1, PROT, 8'h21, 1'b0);
    cyc(1'b1, PROT, 8'h22, 1'b0);
    check({7'd0, perm_s}, 8'd1, "R9 second write permitted");
    check({7'd0, win_open}, 8'd1, "R9 window survives writes");
    check(prot_reg, 8'h22, "R9 reg holds last write");
    cyc(1'b1, KA, 8'h55, 1'b0);
    check({7'd0, perm_s}, 8'd0, "R5 key write not permitted");
    check({7'd0, win_open}, 8'd0, "R6 0x55 while open closes");
  endtask

  task automatic t_no_first();
    cyc(1'b1, KA, 8'h55, 1'b0);
    check({7'd0, win_open}, 8'd0, "R3 lone 0x55 ignored");
    cyc(1'b1, 8'hC6, 8'hAA, 1'b0);
    cyc(1'b1, KA, 8'h55, 1'b0);
    check({7'd0, win_open}, 8'd0, "R3 0xAA at other address ignored");
  endtask

  task automatic t_bad_key();
    cyc(1'b1, KA, 8'hAA, 1'b0);
    cyc(1'b1, KA, 8'h33, 1'b0);
    cyc(1'b1, KA, 8'h55, 1'b0);
    check({7'd0, win_open}, 8'd0, "R6 stray value aborts arm");
    open_seq();
    cyc(1'b1, KA, 8'h12, 1'b0);
    check({7'd0, win_open}, 8'd0, "R6 stray value closes window");
  endtask

  task automatic t_gap();
    cyc(1'b1, KA, 8'hAA, 1'b0);
    idle(1'b1);
    idle(1'b1);
    cyc(1'b1, KA, 8'h55, 1'b1);
    check({7'd0, win_open}, 8'd1, "R7 R10 0x55 on third tick accepted");
    cyc(1'b1, KA, 8'h00, 1'b0);
    cyc(1'b1, KA, 8'hAA, 1'b0);
    idle(1'b1);
    idle(1'b1);
    idle(1'b1);
    cyc(1'b1, KA, 8'h55, 1'b0);
    check({7'd0, win_open}, 8'd0, "R7 late 0x55 rejected");
    cyc(1'b1, KA, 8'hAA, 1'b1);
    idle(1'b1);
    idle(1'b1);
    cyc(1'b1, KA, 8'h55, 1'b0);
    check({7'd0, win_open}, 8'd1, "R10 tick with 0xAA not counted");
    cyc(1'b1, KA, 8'h00, 1'b0);
  endtask

  task automatic t_restart();
    open_seq();
    cyc(1'b1, KA, 8'hAA, 1'b0);
    check({7'd0, win_open}, 8'd0, "R8 0xAA closes window");
    cyc(1'b1, KA, 8'h55, 1'b0);
    check({7'd0, win_open}, 8'd1, "R8 re-armed then opened");
    cyc(1'b1, KA, 8'h00, 1'b0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    prot_reg = 8'h00;
    rst_n = 1'b0; cyc_tick = 1'b0; bus_wr = 1'b0;
    bus_addr = 8'h00; bus_wdata = 8'h00; perm_s = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_open_and_len();
    t_multi_write();
    t_no_first();
    t_bad_key();
    t_gap();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule